// File: doc/BRIEF.md
# Power Mode Controller with Wake-up

This block is the mode sequencer of a power-management companion device that sits beside a microcontroller. It moves between five modes: Start-up, Normal, Standby, Sleep and Flash. Software drives it by writing command codes into a mode register through a simple register port. The block drives the microcontroller's reset line, the main supply enable and the inhibit output enable, and it raises an interrupt. It also keeps a code that tells software why the last reset happened.

In Standby, software picks for each wake-up source whether it raises an interrupt or forces a reset. The sources are watchdog overflow, bus activity, supply-current rise and a falling edge on the wake pin. Once an interrupt is raised it must be read within a fixed number of cycles; if it is not, the block forces a reset. Sleep removes power from the microcontroller. Sleep ends on a watchdog overflow, bus activity, a wake-pin falling edge, or an overload of the auxiliary supply while that supply is enabled. Flash mode can be reached only from Normal, through a fixed three-write sequence in which every write falls inside the watchdog's legal window.

The watchdog timer itself, the SPI shifter, the regulators and the bus transceiver are not part of this block. Watchdog overflow, bus activity, current rise and auxiliary overload reach the block as single-cycle event pulses.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset the mode is Start-up (code 0), `rst_src` is 0, `irq` is low and `v1_en` and `inh_oe` are high. `rstn_out` stays low for RST_LEN cycles and then goes high.
- R2: Mode codes are Start-up 0, Normal 1, Standby 2, Sleep 3, Flash 4. Writing command 1 sets Normal, 2 sets Standby and 3 sets Sleep. A write takes effect on the clock edge after it. In Start-up, commands 1 and 2 are accepted only after `rstn_out` has gone high.
- R3: Command 3 moves the block from Normal or Standby to Sleep. From the edge that enters Sleep, `rstn_out`, `v1_en` and `inh_oe` are all low. Register writes made in Sleep have no effect.
- R4: In Standby, `wake_as_reset` selects the action per source: bit 0 watchdog, bit 1 bus, bit 2 current, bit 3 wake pin. A bit at 1 forces Start-up with a reset pulse. A bit at 0 raises `irq` and leaves the block in Standby.
- R5: A current-rise wake routed to interrupt keeps `rstn_out` and `v1_en` high, so microcontroller RAM stays valid.
- R6: The wake pin passes through a two-flop synchronizer, and only a falling edge counts as a wake event. Holding the pin low or driving it high raises nothing.
- R7: A pulse on `irq_rd` clears `irq` and stops its deadline. After a timely read, software may request Normal. If `irq` has been pending for IRQ_TMO cycles, the block forces Start-up with reset source 2.
- R8: In Sleep these events force Start-up and re-enable `v1_en`: watchdog overflow (source 1), bus activity (source 3) and a wake-pin falling edge (source 4). An auxiliary overload also wakes the block with source 6, but only when `aux_mode` is 1 (on) or 2 (cyclic). With `aux_mode` at 0 (off) the overload is ignored.
- R9: In Normal, three consecutive writes of 0xA, 0x5 and 0xC, each made with `wd_win_ok` high, enter Flash on the edge after the third write. The first two writes leave the mode unchanged.
- R10: The sequence starts over, and no mode change follows, in any of these cases: a write with the wrong code, a write with `wd_win_ok` low, or any other write placed between the three.
- R11: Flash is entered only from Normal. The three-write sequence has no effect in Standby.
- R12: A watchdog overflow in Normal or Flash forces Start-up with source 1. Command 1 moves Flash back to Normal.
- R13: `rst_src` holds 1 for watchdog overflow, 2 for interrupt timeout, 3 for bus wake, 4 for wake-pin wake, 5 for current wake and 6 for overload wake. It changes only when Start-up is entered and keeps its value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_mode | input | 1 | Mode register write strobe |
| wr_code | input | 4 | Value written to the mode register |
| irq_rd | input | 1 | Interrupt register read strobe |
| wake_as_reset | input | 4 | Per-source routing: 1 reset, 0 interrupt |
| aux_mode | input | 2 | Auxiliary supply setting: 0 off, 1 on, 2 cyclic |
| wd_overflow | input | 1 | Watchdog overflow pulse |
| wd_win_ok | input | 1 | Watchdog window currently legal |
| bus_act | input | 1 | Bus activity pulse |
| wake_pin | input | 1 | Asynchronous wake pin, idle high |
| icc_wake | input | 1 | Supply-current rise pulse |
| aux_ovl | input | 1 | Auxiliary supply overload pulse |
| rstn_out | output | 1 | Reset to the microcontroller, active low |
| v1_en | output | 1 | Main supply enable |
| inh_oe | output | 1 | Inhibit output drive enable (0 = floating) |
| irq | output | 1 | Interrupt pending |
| mode | output | 3 | Current mode code |
| rst_src | output | 3 | Last reset source code |

## Verification
The assertions watch on every cycle that all three power and reset outputs are low in Sleep and that Start-up is always entered with reset asserted. They also check that Sleep exits only to Start-up and that Flash is never entered except from Normal with a windowed 0xC write. A further check is that the reset-source code changes only when Start-up is entered. The bench scenarios cover what needs a stimulus history: the per-source routing, and the interrupt deadline both with and without a read. They also cover the synchronized pin edge, the auxiliary-supply gating in Sleep, and the ways a Flash sequence can be aborted and restarted.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      M_STARTUP = 3'd0,
      M_NORMAL  = 3'd1,
      M_STANDBY = 3'd2,
      M_SLEEP   = 3'd3,
      M_FLASH   = 3'd4
   } pmc_mode_e;

   localparam int CODE_W = 4;
   localparam logic [CODE_W-1:0] CMD_NORMAL  = 4'h1;
   localparam logic [CODE_W-1:0] CMD_STANDBY = 4'h2;
   localparam logic [CODE_W-1:0] CMD_SLEEP   = 4'h3;

   localparam int N_WAKE   = 4;
   localparam int WK_WDOG  = 0;
   localparam int WK_BUS   = 1;
   localparam int WK_CURR  = 2;
   localparam int WK_PIN   = 3;

   localparam logic [2:0] SRC_POR  = 3'd0;
   localparam logic [2:0] SRC_WDOG = 3'd1;
   localparam logic [2:0] SRC_TMO  = 3'd2;
   localparam logic [2:0] SRC_BUS  = 3'd3;
   localparam logic [2:0] SRC_PIN  = 3'd4;
   localparam logic [2:0] SRC_CURR = 3'd5;
   localparam logic [2:0] SRC_OVL  = 3'd6;
endpackage

// File: rtl/pmc_pin_edge.sv
module pmc_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmc_pin_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= sync_q[STAGES-1];
   end

   assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/pmc_irq_timer.sv
module pmc_irq_timer #(
   parameter int IRQ_TMO = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic flush,
   output logic pending,
   output logic expire
);
   localparam int CW = $clog2(IRQ_TMO + 1);

   if (IRQ_TMO < 2) begin : g_bad_tmo
      $error("pmc_irq_timer: IRQ_TMO must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (flush) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (set) begin
         pend_q <= 1'b1;
         cnt_q  <= CW'(IRQ_TMO - 1);
      end else if (clr) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (pend_q && cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign pending = pend_q;
   assign expire  = pend_q && (cnt_q == '0);
endmodule

// File: rtl/pmc_flash_seq.sv
module pmc_flash_seq #(
   parameter int              CODE_W = 4,
   parameter logic [CODE_W-1:0] KEY_A = 4'hA,
   parameter logic [CODE_W-1:0] KEY_B = 4'h5,
   parameter logic [CODE_W-1:0] KEY_C = 4'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [CODE_W-1:0] code,
   input  logic              win_ok,
   output logic              go
);
   localparam int NSTEP = 3;
   localparam int SW    = $clog2(NSTEP);

   if (KEY_A == KEY_B || KEY_B == KEY_C || KEY_A == KEY_C) begin : g_bad_keys
      $error("pmc_flash_seq: sequence keys must differ");
   end

   logic [SW-1:0]     step_q;
   logic [CODE_W-1:0] want;
   logic              hit;

   always_comb begin
      case (step_q)
         SW'(0):  want = KEY_A;
         SW'(1):  want = KEY_B;
         default: want = KEY_C;
      endcase
   end

   assign hit = en && wr && win_ok && (code == want);
   assign go  = hit && (step_q == SW'(NSTEP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 step_q <= '0;
      else if (!en)               step_q <= '0;
      else if (wr) begin
         if (hit && !go)          step_q <= step_q + 1'b1;
         else                     step_q <= '0;
      end
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int              RST_LEN     = 16,
   parameter int              IRQ_TMO     = 200,
   parameter int              SYNC_STAGES = 2,
   parameter logic [3:0]      FLASH_A     = 4'hA,
   parameter logic [3:0]      FLASH_B     = 4'h5,
   parameter logic [3:0]      FLASH_C     = 4'hC
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_mode,
   input  logic [3:0] wr_code,
   input  logic       irq_rd,
   input  logic [3:0] wake_as_reset,
   input  logic [1:0] aux_mode,
   input  logic       wd_overflow,
   input  logic       wd_win_ok,
   input  logic       bus_act,
   input  logic       wake_pin,
   input  logic       icc_wake,
   input  logic       aux_ovl,
   output logic       rstn_out,
   output logic       v1_en,
   output logic       inh_oe,
   output logic       irq,
   output logic [2:0] mode,
   output logic [2:0] rst_src
);
   localparam int RCW = $clog2(RST_LEN + 1);

   if (RST_LEN < 1) begin : g_bad_rst_len
      $error("pwr_mode_ctrl: RST_LEN must be at least 1");
   end
   if (FLASH_A <= CMD_SLEEP || FLASH_B <= CMD_SLEEP || FLASH_C <= CMD_SLEEP) begin : g_bad_flash_key
      $error("pwr_mode_ctrl: flash keys must not collide with mode commands");
   end

   pmc_mode_e  mode_q, mode_d;
   logic [RCW-1:0] rcnt_q;
   logic [2:0] src_q, src_d;
   logic       go_start;
   logic       pin_fall;
   logic       irq_pend, irq_exp, irq_set, tmr_flush;
   logic       flash_go;
   logic       released;
   logic [N_WAKE-1:0] wk_ev;

   pmc_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (wake_pin),
      .fall (pin_fall)
   );

   pmc_flash_seq #(.CODE_W(CODE_W), .KEY_A(FLASH_A), .KEY_B(FLASH_B), .KEY_C(FLASH_C)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode_q == M_NORMAL),
      .wr    (wr_mode),
      .code  (wr_code),
      .win_ok(wd_win_ok),
      .go    (flash_go)
   );

   pmc_irq_timer #(.IRQ_TMO(IRQ_TMO)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (irq_set),
      .clr    (irq_rd),
      .flush  (tmr_flush),
      .pending(irq_pend),
      .expire (irq_exp)
   );

   assign released = (rcnt_q == '0);

   always_comb begin
      wk_ev          = '0;
      wk_ev[WK_WDOG] = wd_overflow;
      wk_ev[WK_BUS]  = bus_act;
      wk_ev[WK_CURR] = icc_wake;
      wk_ev[WK_PIN]  = pin_fall;
   end

   always_comb begin
      mode_d   = mode_q;
      src_d    = src_q;
      go_start = 1'b0;
      irq_set  = 1'b0;
      case (mode_q)
         M_STARTUP: begin
            if (released && wr_mode) begin
               if (wr_code == CMD_NORMAL)       mode_d = M_NORMAL;
               else if (wr_code == CMD_STANDBY) mode_d = M_STANDBY;
            end
         end
         M_NORMAL: begin
            if (irq_exp)          begin go_start = 1'b1; src_d = SRC_TMO;  end
            else if (wd_overflow) begin go_start = 1'b1; src_d = SRC_WDOG; end
            else if (flash_go)    mode_d = M_FLASH;
            else if (wr_mode) begin
               if (wr_code == CMD_STANDBY)    mode_d = M_STANDBY;
               else if (wr_code == CMD_SLEEP) mode_d = M_SLEEP;
            end
         end
         M_FLASH: begin
            if (irq_exp)          begin go_start = 1'b1; src_d = SRC_TMO;  end
            else if (wd_overflow) begin go_start = 1'b1; src_d = SRC_WDOG; end
            else if (wr_mode && wr_code == CMD_NORMAL) mode_d = M_NORMAL;
         end
         M_STANDBY: begin
            if (irq_exp) begin go_start = 1'b1; src_d = SRC_TMO; end
            else if (wk_ev[WK_WDOG] && wake_as_reset[WK_WDOG]) begin go_start = 1'b1; src_d = SRC_WDOG; end
            else if (wk_ev[WK_BUS]  && wake_as_reset[WK_BUS])  begin go_start = 1'b1; src_d = SRC_BUS;  end
            else if (wk_ev[WK_PIN]  && wake_as_reset[WK_PIN])  begin go_start = 1'b1; src_d = SRC_PIN;  end
            else if (wk_ev[WK_CURR] && wake_as_reset[WK_CURR]) begin go_start = 1'b1; src_d = SRC_CURR; end
            else begin
               irq_set = |(wk_ev & ~wake_as_reset);
               if (wr_mode) begin
                  if (wr_code == CMD_NORMAL)     mode_d = M_NORMAL;
                  else if (wr_code == CMD_SLEEP) mode_d = M_SLEEP;
               end
            end
         end
         M_SLEEP: begin
            if (wd_overflow)                   begin go_start = 1'b1; src_d = SRC_WDOG; end
            else if (bus_act)                  begin go_start = 1'b1; src_d = SRC_BUS;  end
            else if (pin_fall)                 begin go_start = 1'b1; src_d = SRC_PIN;  end
            else if (aux_ovl && aux_mode != 2'd0) begin go_start = 1'b1; src_d = SRC_OVL; end
         end
         default: begin go_start = 1'b1; src_d = SRC_POR; end
      endcase
      if (go_start) mode_d = M_STARTUP;
   end

   assign tmr_flush = go_start || (mode_d == M_SLEEP && mode_q != M_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_STARTUP;
         src_q  <= SRC_POR;
         rcnt_q <= RCW'(RST_LEN);
      end else begin
         mode_q <= mode_d;
         src_q  <= src_d;
         if (go_start)       rcnt_q <= RCW'(RST_LEN);
         else if (!released) rcnt_q <= rcnt_q - 1'b1;
      end
   end

   assign rstn_out = (mode_q != M_SLEEP) && released;
   assign v1_en    = (mode_q != M_SLEEP);
   assign inh_oe   = (mode_q != M_SLEEP);
   assign irq      = irq_pend;
   assign mode     = mode_q;
   assign rst_src  = src_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
   import pmc_pkg::*;
#(
   parameter logic [3:0] FLASH_C = 4'hC
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_mode,
   input logic [3:0] wr_code,
   input logic       wd_win_ok,
   input logic       rstn_out,
   input logic       v1_en,
   input logic       inh_oe,
   input logic [2:0] mode,
   input logic [2:0] rst_src
);
   localparam logic [2:0] MD_START = 3'(M_STARTUP);
   localparam logic [2:0] MD_NORM  = 3'(M_NORMAL);
   localparam logic [2:0] MD_SLEEP = 3'(M_SLEEP);
   localparam logic [2:0] MD_FLASH = 3'(M_FLASH);

   AST_SLEEP_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SLEEP) |-> (!rstn_out && !v1_en && !inh_oe)); // R3

   AST_STARTUP_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_START && $past(mode) != MD_START) |-> !rstn_out); // R8

   AST_SLEEP_EXITS_TO_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == MD_SLEEP && mode != MD_SLEEP) |-> mode == MD_START); // R8

   AST_FLASH_ONLY_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_NORM && mode != MD_FLASH) |=> mode != MD_FLASH); // R11

   AST_FLASH_NEEDS_WINDOWED_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_NORM && !(wr_mode && wd_win_ok && wr_code == FLASH_C)) |=> mode != MD_FLASH); // R9

   AST_SRC_CHANGES_ON_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rst_src) |-> mode == MD_START); // R13
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.FLASH_C(FLASH_C)) u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
   localparam int RST_LEN = 16;
   localparam int IRQ_TMO = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_mode = 1'b0;
   logic [3:0] wr_code = '0;
   logic       irq_rd = 1'b0;
   logic [3:0] wake_as_reset = '0;
   logic [1:0] aux_mode = '0;
   logic       wd_overflow = 1'b0;
   logic       wd_win_ok = 1'b0;
   logic       bus_act = 1'b0;
   logic       wake_pin = 1'b1;
   logic       icc_wake = 1'b0;
   logic       aux_ovl = 1'b0;
   logic       rstn_out, v1_en, inh_oe, irq;
   logic [2:0] mode, rst_src;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pwr_mode_ctrl #(.RST_LEN(RST_LEN), .IRQ_TMO(IRQ_TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_code(wr_code), .irq_rd(irq_rd),
      .wake_as_reset(wake_as_reset), .aux_mode(aux_mode), .wd_overflow(wd_overflow),
      .wd_win_ok(wd_win_ok), .bus_act(bus_act), .wake_pin(wake_pin), .icc_wake(icc_wake),
      .aux_ovl(aux_ovl), .rstn_out(rstn_out), .v1_en(v1_en), .inh_oe(inh_oe), .irq(irq),
      .mode(mode), .rst_src(rst_src)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_mode = 0; irq_rd = 0; wd_overflow = 0; bus_act = 0;
      icc_wake = 0; aux_ovl = 0; wake_pin = 1; wd_win_ok = 0;
      wake_as_reset = '0; aux_mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] c, input logic w);
      @(negedge clk);
      wr_mode = 1'b1; wr_code = c; wd_win_ok = w;
      @(negedge clk);
      wr_mode = 1'b0; wd_win_ok = 1'b0;
   endtask

   // 0 watchdog, 1 bus, 2 current, 3 overload, 4 irq read
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: wd_overflow = 1'b1;
         1: bus_act = 1'b1;
         2: icc_wake = 1'b1;
         3: aux_ovl = 1'b1;
         default: irq_rd = 1'b1;
      endcase
      @(negedge clk);
      wd_overflow = 0; bus_act = 0; icc_wake = 0; aux_ovl = 0; irq_rd = 0;
   endtask

   task automatic go_mode(input logic [3:0] c);
      do_reset();
      repeat (RST_LEN + 2) @(negedge clk);
      wr(c, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk("R1 mode", mode, 0);
      chk("R1 rst_src", rst_src, 0);
      chk("R1 rstn_out low", rstn_out, 0);
      chk("R1 v1_en", v1_en, 1);
      chk("R1 irq", irq, 0);
      wr(4'h1, 1'b0);
      chk("R2 write before release ignored", mode, 0);
      repeat (RST_LEN) @(negedge clk);
      chk("R1 rstn_out released", rstn_out, 1);
   endtask

   task automatic t_commands();
      go_mode(4'h1);
      chk("R2 normal", mode, 1);
      wr(4'h2, 1'b0);
      chk("R2 standby", mode, 2);
      wr(4'h1, 1'b0);
      chk("R2 back to normal", mode, 1);
   endtask

   task automatic t_sleep();
      go_mode(4'h2);
      wr(4'h3, 1'b0);
      chk("R3 sleep mode", mode, 3);
      chk("R3 rstn_out", rstn_out, 0);
      chk("R3 v1_en", v1_en, 0);
      chk("R3 inh_oe", inh_oe, 0);
      wr(4'h1, 1'b0);
      chk("R3 write ignored in sleep", mode, 3);
   endtask

   task automatic t_route();
      go_mode(4'h2);
      wake_as_reset = 4'b0000;
      pulse(0);
      chk("R4 wd irq route irq", irq, 1);
      chk("R4 wd irq route mode", mode, 2);
      pulse(4);
      chk("R7 read clears irq", irq, 0);
      wake_as_reset = 4'b0001;
      pulse(0);
      chk("R4 wd reset route mode", mode, 0);
      chk("R4 R13 wd src", rst_src, 1);
      chk("R4 reset pulse", rstn_out, 0);
      go_mode(4'h2);
      wake_as_reset = 4'b0010;
      pulse(1);
      chk("R4 bus reset mode", mode, 0);
      chk("R13 bus src", rst_src, 3);
      repeat (RST_LEN + 2) @(negedge clk);
      wr(4'h1, 1'b0);
      chk("R13 src holds in normal", rst_src, 3);
   endtask

   task automatic t_current();
      go_mode(4'h2);
      wake_as_reset = 4'b0000;
      pulse(2);
      chk("R5 current irq", irq, 1);
      chk("R5 rstn_out kept high", rstn_out, 1);
      chk("R5 v1_en kept high", v1_en, 1);
      chk("R5 mode standby", mode, 2);
      pulse(4);
      wake_as_reset = 4'b0100;
      pulse(2);
      chk("R4 current reset mode", mode, 0);
      chk("R13 current src", rst_src, 5);
   endtask

   task automatic t_pin();
      go_mode(4'h2);
      wake_as_reset = 4'b0000;
      @(negedge clk); wake_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk("R6 fall raises irq", irq, 1);
      pulse(4);
      repeat (10) @(negedge clk);
      chk("R6 held low no irq", irq, 0);
      wake_pin = 1'b1;
      repeat (6) @(negedge clk);
      chk("R6 rise no irq", irq, 0);
      wake_as_reset = 4'b1000;
      wake_pin = 1'b0;
      @(negedge clk);
      chk("R6 synchronizer delay", mode, 2);
      repeat (5) @(negedge clk);
      chk("R6 pin reset mode", mode, 0);
      chk("R13 pin src", rst_src, 4);
      wake_pin = 1'b1;
   endtask

   task automatic t_deadline();
      go_mode(4'h2);
      wake_as_reset = 4'b0000;
      pulse(1);
      chk("R7 irq set", irq, 1);
      repeat (IRQ_TMO / 2) @(negedge clk);
      pulse(4);
      repeat (IRQ_TMO + 20) @(negedge clk);
      chk("R7 timely read no reset", mode, 2);
      wr(4'h1, 1'b0);
      chk("R7 normal after read", mode, 1);
      wr(4'h2, 1'b0);
      pulse(1);
      repeat (IRQ_TMO + 8) @(negedge clk);
      chk("R7 timeout mode", mode, 0);
      chk("R7 timeout src", rst_src, 2);
      chk("R7 irq cleared by reset", irq, 0);
   endtask

   task automatic t_sleep_wake(input int which, input int exp_src, input string tag);
      go_mode(4'h1);
      wr(4'h3, 1'b0);
      if (which == 5) begin
         @(negedge clk); wake_pin = 1'b0;
         repeat (5) @(negedge clk);
         wake_pin = 1'b1;
      end else begin
         pulse(which);
      end
      chk({tag, " mode"}, mode, 0);
      chk({tag, " src"}, rst_src, exp_src);
      chk({tag, " v1_en"}, v1_en, 1);
   endtask

   task automatic t_aux();
      go_mode(4'h1);
      wr(4'h3, 1'b0);
      aux_mode = 2'd0;
      pulse(3);
      chk("R8 overload ignored aux off", mode, 3);
      aux_mode = 2'd2;
      pulse(3);
      chk("R8 overload cyclic mode", mode, 0);
      chk("R8 overload src", rst_src, 6);
      go_mode(4'h1);
      wr(4'h3, 1'b0);
      aux_mode = 2'd1;
      pulse(3);
      chk("R8 overload on mode", mode, 0);
   endtask

   task automatic t_flash();
      go_mode(4'h1);
      wr(4'hA, 1'b1);
      chk("R9 after first key", mode, 1);
      wr(4'h5, 1'b1);
      chk("R9 after second key", mode, 1);
      wr(4'hC, 1'b1);
      chk("R9 flash entered", mode, 4);
      wr(4'h1, 1'b0);
      chk("R12 flash to normal", mode, 1);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'hC, 1'b1);
      pulse(0);
      chk("R12 wd in flash mode", mode, 0);
      chk("R12 wd in flash src", rst_src, 1);
   endtask

   task automatic t_flash_abort();
      go_mode(4'h1);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'hA, 1'b1); wr(4'hC, 1'b1);
      chk("R10 wrong code abort", mode, 1);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'hC, 1'b0);
      chk("R10 out of window abort", mode, 1);
      wr(4'hC, 1'b1);
      chk("R10 lone C no entry", mode, 1);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'h1, 1'b1); wr(4'hC, 1'b1);
      chk("R10 intervening write abort", mode, 1);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'hC, 1'b1);
      chk("R10 restart then enter", mode, 4);
      pulse(0);
      chk("R12 wd in normal path src", rst_src, 1);
   endtask

   task automatic t_flash_standby();
      go_mode(4'h2);
      wr(4'hA, 1'b1); wr(4'h5, 1'b1); wr(4'hC, 1'b1);
      chk("R11 no flash from standby", mode, 2);
      go_mode(4'h1);
      pulse(0);
      chk("R12 wd in normal mode", mode, 0);
   endtask

   initial begin
      t_reset();
      t_commands();
      t_sleep();
      t_route();
      t_current();
      t_pin();
      t_deadline();
      t_sleep_wake(0, 1, "R8 sleep wd");
      t_sleep_wake(1, 3, "R8 sleep bus");
      t_sleep_wake(5, 4, "R8 sleep pin");
      t_aux();
      t_flash();
      t_flash_abort();
      t_flash_standby();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule